// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register face of a simple byte-oriented serial port. A processor reaches it through a word-indexed register bus: control, mask and acknowledge registers are written, and status, receive data and interrupt state are read back. Outgoing bytes leave as a byte and a one-cycle strobe. Incoming bytes arrive as a byte and a strobe, gated by a combinational ready signal. A single level-sensitive interrupt line reports masked events.

Two interrupt sources exist. Bit 0 flags that a byte was transmitted, and bit 3 flags that a byte was received. Software clears them by writing a one-shot acknowledge register. The received byte and its data-available flag share one status word. That word can be read at two indices: one read clears the flag, the other leaves it alone. Line serialization, baud timing, DMA and queuing belong to neighbouring blocks.

Top module: `sio_port_front`

## Requirements
- R1: After synchronous reset, every stored register is zero, `irq` and `tx_valid` are low, and the status word reads 0x0140_0000 (transmitter-ready bit 24 and transmitter-idle bit 22 set, data-available bit 16 clear, data byte zero).
- R2: `bus_rdata` combinationally shows the word at `bus_addr`. Word indices: 0 transmit control, 1 DMA enable, 2 receive control, 7 data out, 8 status with read-clear, 9 status without side effect, 11 mask, 12 acknowledge, 13 raw interrupt, 14 masked interrupt. Writes to indices 0, 1, 2 and 11 store all 32 bits. Indices 3 to 6, 10 and 15 read zero, and so does index 7. Writes to 8, 9, 13 and 14 are ignored.
- R3: A write to index 7 drives `tx_valid` high for exactly the following cycle, with `tx_data` equal to the low 8 bits written. Raw interrupt bit 0 is set at that same edge.
- R4: A receive byte accepted on an edge places the byte in status bits 7:0, sets status bit 16 and sets raw interrupt bit 3, all visible from the next cycle.
- R5: `rx_ready` is combinationally high when receive-control bit 0 is set or raw bit 3 is clear. A byte offered while `rx_ready` is low is dropped and changes neither the status word nor the raw bits.
- R6: A read of index 8 clears status bit 16 at the next edge, and a read of index 9 leaves it unchanged. If a byte is accepted on the same edge, the flag ends set.
- R7: A value written to index 12 is held for one cycle. At the following edge the raw bits it names are cleared and the register returns to zero. A transmit or receive event on that edge keeps its own bit set.
- R8: Index 14 reads raw AND mask, and `irq` is high exactly when that value is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for the read side effect) |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Block can accept a receive byte |
| irq | output | 1 | Level interrupt |

## Verification
A wrong raw-interrupt bit appears on `irq` and `rx_ready` in the same cycle, and on the raw and masked read-back at once. A stale acknowledge value would clear events one or more cycles late, and this shows as a raw bit surviving or vanishing at the edge after the acknowledge is applied. Errors in the data-available flag appear on the next status read, and dropped or extra bytes appear on the next cycle's `tx_valid` or status data. The bench compares every output against its own model on every cycle, so any divergence is caught within one cycle of becoming visible.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    // word indices of the register window
    localparam logic [ADDR_W-1:0] IDX_TXCTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] IDX_DMAEN   = 4'd1;
    localparam logic [ADDR_W-1:0] IDX_RXCTRL  = 4'd2;
    localparam logic [ADDR_W-1:0] IDX_DOUT    = 4'd7;
    localparam logic [ADDR_W-1:0] IDX_STATCLR = 4'd8;
    localparam logic [ADDR_W-1:0] IDX_STATPK  = 4'd9;
    localparam logic [ADDR_W-1:0] IDX_MASK    = 4'd11;
    localparam logic [ADDR_W-1:0] IDX_ACK     = 4'd12;
    localparam logic [ADDR_W-1:0] IDX_RAW     = 4'd13;
    localparam logic [ADDR_W-1:0] IDX_MASKED  = 4'd14;

    // status word bit positions
    localparam int ST_DAV     = 16;
    localparam int ST_TX_IDLE = 22;
    localparam int ST_TX_RDY  = 24;

    // interrupt bit positions
    localparam int IRQ_TXDONE = 0;
    localparam int IRQ_RXDATA = 3;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] idx;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] tx_ctrl;
        logic [DATA_W-1:0] dma_en;
        logic [DATA_W-1:0] rx_ctrl;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] ack;
    } ctrl_bank_t;

    function automatic logic wr_hit(bus_req_t q, logic [ADDR_W-1:0] idx);
        return q.wr && (q.idx == idx);
    endfunction

    function automatic logic rd_hit(bus_req_t q, logic [ADDR_W-1:0] idx);
        return q.rd && (q.idx == idx);
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(logic dav, logic [BYTE_W-1:0] data);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_TX_RDY]    = 1'b1;
        w[ST_TX_IDLE]   = 1'b1;
        w[ST_DAV]       = dav;
        w[BYTE_W-1:0]   = data;
        return w;
    endfunction

endpackage

// File: rtl/sio_ctrl_regs.sv
module sio_ctrl_regs
    import sio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_req_t   req,
    output ctrl_bank_t bank
);

    localparam int N_STORE = 4;
    localparam logic [N_STORE*ADDR_W-1:0] STORE_IDX =
        {IDX_MASK, IDX_RXCTRL, IDX_DMAEN, IDX_TXCTRL};

    logic [DATA_W-1:0] store_q [N_STORE];

    for (genvar g = 0; g < N_STORE; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst)
                store_q[g] <= '0;
            else if (wr_hit(req, STORE_IDX[g*ADDR_W +: ADDR_W]))
                store_q[g] <= req.wdata;
        end
    end

    // one-shot acknowledge: holds a written value for exactly one cycle
    logic [DATA_W-1:0] ack_q;
    always_ff @(posedge clk) begin
        if (rst)
            ack_q <= '0;
        else if (wr_hit(req, IDX_ACK))
            ack_q <= req.wdata;
        else
            ack_q <= '0;
    end

    always_comb begin
        bank.tx_ctrl = store_q[0];
        bank.dma_en  = store_q[1];
        bank.rx_ctrl = store_q[2];
        bank.mask    = store_q[3];
        bank.ack     = ack_q;
    end

endmodule

// File: rtl/sio_irq_unit.sv
module sio_irq_unit
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] ack,
    input  logic [DATA_W-1:0] events,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] masked,
    output logic              irq
);

    logic [DATA_W-1:0] raw_q;

    // acknowledge clears first, events of the same edge win
    always_ff @(posedge clk) begin
        if (rst)
            raw_q <= '0;
        else
            raw_q <= (raw_q & ~ack) | events;
    end

    always_comb begin
        raw    = raw_q;
        masked = raw_q & mask;
        irq    = |masked;
    end

endmodule

// File: rtl/sio_rx_stat.sv
module sio_rx_stat
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_enable,
    input  logic              rx_pending,
    input  logic              rd_clear,
    output logic              rx_ready,
    output logic              rx_accept,
    output logic [DATA_W-1:0] status
);

    logic [BYTE_W-1:0] data_q;
    logic              dav_q;

    always_comb begin
        rx_ready  = rx_enable | ~rx_pending;
        rx_accept = rx_valid & rx_ready;
        status    = stat_word(dav_q, data_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            dav_q  <= 1'b0;
        end else if (rx_accept) begin
            data_q <= rx_data;
            dav_q  <= 1'b1;
        end else if (rd_clear) begin
            dav_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_port_front.sv
module sio_port_front
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic              irq
);

    bus_req_t          req;
    ctrl_bank_t        bank;
    logic [DATA_W-1:0] raw, masked, status, events;
    logic              rx_accept, tx_fire;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.idx   = bus_addr;
        req.wdata = bus_wdata;
    end

    sio_ctrl_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .bank (bank)
    );

    sio_rx_stat u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_enable  (bank.rx_ctrl[0]),
        .rx_pending (raw[IRQ_RXDATA]),
        .rd_clear   (rd_hit(req, IDX_STATCLR)),
        .rx_ready   (rx_ready),
        .rx_accept  (rx_accept),
        .status     (status)
    );

    assign tx_fire = wr_hit(req, IDX_DOUT);

    always_comb begin
        events             = '0;
        events[IRQ_TXDONE] = tx_fire;
        events[IRQ_RXDATA] = rx_accept;
    end

    sio_irq_unit u_irq (
        .clk    (clk),
        .rst    (rst),
        .ack    (bank.ack),
        .events (events),
        .mask   (bank.mask),
        .raw    (raw),
        .masked (masked),
        .irq    (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= tx_fire;
            if (tx_fire)
                tx_data <= bus_wdata[BYTE_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            IDX_TXCTRL:  bus_rdata = bank.tx_ctrl;
            IDX_DMAEN:   bus_rdata = bank.dma_en;
            IDX_RXCTRL:  bus_rdata = bank.rx_ctrl;
            IDX_STATCLR,
            IDX_STATPK:  bus_rdata = status;
            IDX_MASK:    bus_rdata = bank.mask;
            IDX_ACK:     bus_rdata = bank.ack;
            IDX_RAW:     bus_rdata = raw;
            IDX_MASKED:  bus_rdata = masked;
            default:     bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sio_front_chk.sv
module sio_front_chk
    import sio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] tx_data,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [DATA_W-1:0] raw,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] ack,
    input logic [DATA_W-1:0] rx_ctrl
);

    // R3
    tx_strobe_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == IDX_DOUT) |=>
            (tx_valid && tx_data == $past(bus_wdata[BYTE_W-1:0]) && raw[IRQ_TXDONE]));

    // R3
    tx_strobe_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bus_wr && bus_addr == IDX_DOUT));

    // R4
    rx_accept_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_ready) |=> (status[ST_DAV] && raw[IRQ_RXDATA]));

    // R5
    rx_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> (raw[IRQ_RXDATA] && !rx_ctrl[0]));

    // R5
    rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_ready && !(bus_rd && bus_addr == IDX_STATCLR)) |=> $stable(status));

    // R6
    read_clears_dav_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == IDX_STATCLR && !(rx_valid && rx_ready)) |=> !status[ST_DAV]);

    // R7
    ack_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        (ack != '0 && !(bus_wr && bus_addr == IDX_ACK)) |=> (ack == '0));

endmodule

bind sio_port_front sio_front_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .raw       (raw),
    .status    (status),
    .ack       (bank.ack),
    .rx_ctrl   (bank.rx_ctrl)
);

// File: tb/tb_sio_port_front.sv
module tb_sio_port_front;
    import sio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [7:0]  tx_data, rx_data;
    logic        tx_valid, rx_valid, rx_ready, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_port_front dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
    );

    int n_vec = 0;
    int n_bad = 0;

    // bench model of the register state
    logic [31:0] m_txctrl, m_dma, m_rxctrl, m_mask, m_ack, m_raw;
    logic [7:0]  m_rxd, m_txd;
    logic        m_dav, m_txv;

    function automatic logic [31:0] m_stat();
        logic [31:0] w;
        w = 32'h0;
        w[24] = 1'b1;
        w[22] = 1'b1;
        w[16] = m_dav;
        w[7:0] = m_rxd;
        return w;
    endfunction

    function automatic logic [31:0] exp_read(logic [3:0] a);
        case (a)
            4'd0:       return m_txctrl;
            4'd1:       return m_dma;
            4'd2:       return m_rxctrl;
            4'd8, 4'd9: return m_stat();
            4'd11:      return m_mask;
            4'd12:      return m_ack;
            4'd13:      return m_raw;
            4'd14:      return m_raw & m_mask;
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(logic [3:0] a);
        case (a)
            4'd8, 4'd9:         return "R4";
            4'd12, 4'd13:       return "R7";
            4'd14:              return "R8";
            default:            return "R2";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_txctrl = 0; m_dma = 0; m_rxctrl = 0; m_mask = 0; m_ack = 0; m_raw = 0;
        m_rxd = 0; m_txd = 0; m_dav = 0; m_txv = 0;
    endtask

    // one bus cycle: drive at negedge, check outputs, advance model
    task automatic step(logic w, logic r, logic [3:0] a, logic [31:0] d,
                        logic rv, logic [7:0] rd);
        logic        acc;
        logic [31:0] ev;
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rd;
        #1;
        check(read_tag(a), bus_rdata, exp_read(a));
        check("R3", {31'b0, tx_valid}, {31'b0, m_txv});
        if (m_txv) check("R3", {24'b0, tx_data}, {24'b0, m_txd});
        check("R5", {31'b0, rx_ready}, {31'b0, m_rxctrl[0] | ~m_raw[3]});
        check("R8", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
        // next state
        acc = rv && (m_rxctrl[0] || !m_raw[3]);
        ev = 32'h0;
        ev[0] = w && a == 4'd7;
        ev[3] = acc;
        m_raw = (m_raw & ~m_ack) | ev;
        m_ack = (w && a == 4'd12) ? d : 32'h0;
        if (acc) begin
            m_rxd = rd; m_dav = 1'b1;
        end else if (r && a == 4'd8) begin
            m_dav = 1'b0;
        end
        m_txv = w && a == 4'd7;
        if (m_txv) m_txd = d[7:0];
        if (w && a == 4'd0)  m_txctrl = d;
        if (w && a == 4'd1)  m_dma = d;
        if (w && a == 4'd2)  m_rxctrl = d;
        if (w && a == 4'd11) m_mask = d;
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, 8'h00);
    endtask

    task automatic rd(logic [3:0] a);
        step(1'b0, 1'b1, a, 32'h0, 1'b0, 8'h00);
    endtask

    task automatic rx(logic [7:0] b);
        step(1'b0, 1'b0, 4'd9, 32'h0, 1'b1, b);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
        rx_valid = 0; rx_data = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        bus_addr = 4'd9; #1;
        check("R1", bus_rdata, 32'h0140_0000);
        bus_addr = 4'd13; #1;
        check("R1", bus_rdata, 32'h0);
        bus_addr = 4'd11; #1;
        check("R1", bus_rdata, 32'h0);
        check("R1", {31'b0, irq}, 32'h0);
        check("R1", {31'b0, tx_valid}, 32'h0);

        // R2 storage and unmapped reads
        wr(4'd0, 32'hA5A5_0001);
        wr(4'd1, 32'hDEAD_BEEF);
        wr(4'd11, 32'hFFFF_FFFF);
        wr(4'd13, 32'hFFFF_FFFF);   // raw is read-only
        wr(4'd9, 32'h0000_00FF);    // status is read-only
        for (int i = 0; i < 16; i++) rd(4'(i));

        // R3 transmit, R8 irq
        wr(4'd7, 32'h1234_56C3);
        rd(4'd13);
        rd(4'd14);

        // R4 receive, R5 drop when blocked
        rx(8'h5A);
        rx(8'h77);                  // raw bit 3 set, rx_ctrl bit 0 clear: dropped
        rd(4'd9);
        // R6 read clear versus peek
        rd(4'd9);
        rd(4'd8);
        rd(4'd9);

        // R7 acknowledge and one-shot behaviour
        wr(4'd12, 32'h0000_0009);
        rd(4'd12);
        rd(4'd13);
        rd(4'd12);

        // R7 event on the edge the acknowledge is applied
        wr(4'd2, 32'h1);
        wr(4'd12, 32'h0000_0008);
        rx(8'h3C);
        rd(4'd13);
        // R6 read-clear and receive on the same edge
        step(1'b0, 1'b1, 4'd8, 32'h0, 1'b1, 8'h99);
        rd(4'd9);

        // random traffic
        for (int n = 0; n < N_RANDOM; n++) begin
            logic [3:0]  a;
            logic [31:0] d;
            logic        w, r, rv;
            a  = 4'($urandom_range(0, 15));
            w  = ($urandom_range(0, 99) < 40);
            r  = ($urandom_range(0, 99) < 50);
            d  = $urandom();
            if (a == 4'd12 && ($urandom_range(0, 1) == 0)) d = 32'h9;
            if (a == 4'd2) d = {31'h0, d[0]};
            rv = ($urandom_range(0, 99) < 30);
            step(w, r, a, d, rv, 8'($urandom()));
        end
        step(1'b0, 1'b0, 4'd13, 32'h0, 1'b0, 8'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule